// File: doc/BRIEF.md
# Programmed-setup DMA channel

This block is one direct-memory-access channel that sits inside an I/O device. Software prepares it with three writes over a shared 16-bit bidirectional I/O data port: the first carries the memory buffer address, the second the number of words, and the third the command. The command write is what launches the transfer, and its lowest bit picks the direction.

Once it is running, the channel moves words on its own and supplies every memory address itself, beginning at the loaded address and stepping up by one for each word. A memory cycle takes place only in a clock cycle where the bus grant input is high.

In the memory-to-device direction, each word is read from memory and then offered to the device's sink port. In the device-to-memory direction, each word is taken from the device's source port and then written to memory. When the count reaches zero, the channel goes idle and raises a done flag. Software can read the busy, done and direction flags back over the same data port.

Top module: `dma_channel`

## Requirements
- R1: After reset the channel is idle. The status word reads 0, and mem_req, dev_out_valid and dev_in_ready are all low.
- R2: Setup writes (pio_wr high) are taken in a fixed order: start address, then word count, then command. The command write alone starts the transfer, and busy reads 1 from the next cycle. Command bit 0 set to 1 selects memory-to-device and 0 selects device-to-memory. While pio_rd is high, pio_data carries the status word: bit 0 busy, bit 1 done, bit 2 direction, and all other bits 0.
- R3: The first memory cycle of a transfer uses the start address. After each completed word the address rises by one, wrapping past the top of the address range.
- R4: In memory-to-device mode, the word read at each granted memory cycle is presented on dev_out_data, in order. dev_out_valid and the data are held until dev_out_ready is high.
- R5: In device-to-memory mode, the words accepted with dev_in_valid and dev_in_ready are written to memory in order, with mem_we high and the word on mem_wdata.
- R6: A memory cycle completes only in a cycle where mem_gnt is high. While mem_req is high and the grant is low, mem_req, mem_addr, mem_we and mem_wdata stay unchanged into the next cycle.
- R7: A transfer with count N performs exactly N memory cycles. In the cycle after the last word completes, busy reads 0 and done reads 1. While idle, no request or device handshake is asserted.
- R8: A command written with a count of zero sets done in the next cycle without raising busy and without any memory cycle.
- R9: Writes to the I/O port while busy are ignored. The running transfer continues unchanged, and the next setup again begins with the address.
- R10: The address write of a new setup clears the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pio_wr | input | 1 | Setup write strobe, one word per cycle |
| pio_rd | input | 1 | Status read enable; the block drives pio_data while it is high |
| pio_data | inout | 16 | Bidirectional programmed-I/O data lines |
| mem_req | output | 1 | Memory cycle request |
| mem_gnt | input | 1 | Bus grant; a requested cycle completes when high |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 16 | Memory address supplied by the channel |
| mem_wdata | output | 16 | Inbound bus data to memory |
| mem_rdata | input | 16 | Outbound bus data from memory, valid in the granted cycle |
| dev_out_valid | output | 1 | Word available for the device sink |
| dev_out_ready | input | 1 | Device sink accepts the word |
| dev_out_data | output | 16 | Word for the device sink |
| dev_in_valid | input | 1 | Device source offers a word |
| dev_in_ready | output | 1 | Channel accepts a word from the device |
| dev_in_data | input | 16 | Word from the device source |

## Verification
All handshakes complete on the clock edge that closes the cycle in which both sides are high. The bench therefore evaluates mem_req/mem_gnt and both device handshakes one nanosecond after driving inputs at the falling edge, and it updates its reference queues for the edge that follows. The status flags are due in the cycle after the edge that caused them: one cycle after the command write for busy or for done with a zero count, and one cycle after the last word's handshake for the idle/done change. The bench reads status on every transfer cycle and compares it with the remaining-word count its model holds at that moment. A held request under a low grant is compared against the address it showed one cycle earlier.

// File: rtl/dma_channel.sv
`timescale 1ns/1ps
module dma_channel #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pio_wr,
  input  logic          pio_rd,
  inout  wire  [DW-1:0] pio_data,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          dev_out_valid,
  input  logic          dev_out_ready,
  output logic [DW-1:0] dev_out_data,
  input  logic          dev_in_valid,
  output logic          dev_in_ready,
  input  logic [DW-1:0] dev_in_data
);
  typedef enum logic [1:0] {S_IDLE, S_MEM, S_DEV} state_t;
  typedef enum logic [1:0] {P_ADDR, P_CNT, P_CMD} step_t;

  state_t        state;
  step_t         step;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] word_q;
  logic          to_dev;
  logic          done_q;
  logic          busy;
  logic          finish;
  logic          last;
  logic [DW-1:0] status;

  assign busy          = (state != S_IDLE);
  assign last          = (cnt_q == {{DW-1{1'b0}}, 1'b1});
  assign mem_req       = (state == S_MEM);
  assign mem_we        = (state == S_MEM) && !to_dev;
  assign mem_addr      = addr_q;
  assign mem_wdata     = word_q;
  assign dev_out_valid = (state == S_DEV) && to_dev;
  assign dev_out_data  = word_q;
  assign dev_in_ready  = (state == S_DEV) && !to_dev;
  assign finish        = (state == S_MEM && !to_dev && mem_gnt) ||
                         (state == S_DEV && to_dev && dev_out_ready);
  assign status        = {{DW-3{1'b0}}, to_dev, done_q, busy};
  assign pio_data      = pio_rd ? status : {DW{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      step   <= P_ADDR;
      addr_q <= '0;
      cnt_q  <= '0;
      word_q <= '0;
      to_dev <= 1'b0;
      done_q <= 1'b0;
    end else if (!busy) begin
      if (pio_wr) begin
        case (step)
          P_ADDR: begin
            addr_q <= AW'(pio_data);
            done_q <= 1'b0;
            step   <= P_CNT;
          end
          P_CNT: begin
            cnt_q <= pio_data;
            step  <= P_CMD;
          end
          default: begin
            to_dev <= pio_data[0];
            step   <= P_ADDR;
            if (cnt_q == '0) done_q <= 1'b1;
            else state <= pio_data[0] ? S_MEM : S_DEV;
          end
        endcase
      end
    end else begin
      if (state == S_MEM && to_dev && mem_gnt) begin
        word_q <= mem_rdata;
        state  <= S_DEV;
      end
      if (state == S_DEV && !to_dev && dev_in_valid) begin
        word_q <= dev_in_data;
        state  <= S_MEM;
      end
      if (finish) begin
        addr_q <= addr_q + {{AW-1{1'b0}}, 1'b1};
        cnt_q  <= cnt_q - {{DW-1{1'b0}}, 1'b1};
        if (last) begin
          state  <= S_IDLE;
          done_q <= 1'b1;
        end else begin
          state <= to_dev ? S_MEM : S_DEV;
        end
      end
    end
  end
endmodule

// File: rtl/dma_channel_chk.sv
`timescale 1ns/1ps
module dma_channel_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          dev_out_valid,
  input logic          dev_out_ready,
  input logic [DW-1:0] dev_out_data,
  input logic          dev_in_ready
);
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_wr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt && mem_we |=> mem_addr == $past(mem_addr) + {{AW-1{1'b0}}, 1'b1});

  p_out_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_valid && dev_out_ready |=> mem_addr == $past(mem_addr) + {{AW-1{1'b0}}, 1'b1});

  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_valid && !dev_out_ready |=> dev_out_valid && $stable(dev_out_data));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !dev_out_valid && !dev_in_ready);

  p_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_req, dev_out_valid, dev_in_ready}) <= 1);
endmodule

bind dma_channel dma_channel_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/dma_channel_tb_top.sv
`timescale 1ns/1ps
module dma_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pio_wr = 1'b0, pio_rd = 1'b0, tb_oe = 1'b0;
  logic [15:0] tb_drv = '0;
  wire  [15:0] pio_data;
  logic        mem_req, mem_gnt = 1'b0, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        dev_out_valid, dev_out_ready = 1'b0;
  logic [15:0] dev_out_data;
  logic        dev_in_valid = 1'b0, dev_in_ready;
  logic [15:0] dev_in_data = '0;

  logic [15:0] mem [64];
  logic [15:0] src_q[$];
  logic [15:0] exp_q[$];
  int checks = 0, fails = 0, cyc = 0;
  int gnt_div = 1, rdy_div = 1;
  int remaining = 0, mem_cycles = 0;
  logic [15:0] exp_addr;
  bit dir_m2d;
  bit was_wait = 0;
  logic [15:0] wait_addr;

  assign pio_data  = tb_oe ? tb_drv : 16'hzzzz;
  assign mem_rdata = mem[mem_addr[5:0]];

  always #2.5 clk = ~clk;

  dma_channel dut_i (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit chk_status);
    cyc++;
    mem_gnt       = (gnt_div <= 1) || (cyc % gnt_div != 0);
    dev_out_ready = (rdy_div <= 1) || (cyc % rdy_div != 0);
    dev_in_valid  = (src_q.size() > 0) && ((rdy_div <= 1) || (cyc % rdy_div != 1));
    dev_in_data   = (src_q.size() > 0) ? src_q[0] : 16'h0;
    #1;
    if (chk_status) begin
      check(pio_data[0] == (remaining > 0), "R7 busy flag", pio_data[0], remaining > 0);
      if (remaining > 0) check(pio_data[2] == dir_m2d, "R2 direction flag", pio_data[2], dir_m2d);
    end
    if (was_wait) begin
      check(mem_req && mem_addr == wait_addr, "R6 held request", mem_addr, wait_addr);
    end
    was_wait = mem_req && !mem_gnt;
    wait_addr = mem_addr;
    if (mem_req && mem_gnt) begin
      mem_cycles++;
      check(mem_addr == exp_addr, "R3 address", mem_addr, exp_addr);
      if (mem_we) begin
        if (exp_q.size() == 0) check(0, "R5 unexpected write", mem_wdata, 0);
        else begin
          logic [15:0] e = exp_q.pop_front();
          check(mem_wdata == e, "R5 written word", mem_wdata, e);
        end
        mem[mem_addr[5:0]] = mem_wdata;
        exp_addr++;
        remaining--;
      end else begin
        exp_q.push_back(mem[mem_addr[5:0]]);
      end
    end
    if (dev_out_valid && dev_out_ready) begin
      if (exp_q.size() == 0) check(0, "R4 unexpected word", dev_out_data, 0);
      else begin
        logic [15:0] e = exp_q.pop_front();
        check(dev_out_data == e, "R4 delivered word", dev_out_data, e);
      end
      exp_addr++;
      remaining--;
    end
    if (dev_in_valid && dev_in_ready) exp_q.push_back(src_q.pop_front());
    @(negedge clk);
  endtask

  task automatic pio_write(input logic [15:0] v);
    pio_rd = 0; pio_wr = 1; tb_oe = 1; tb_drv = v;
    step(0);
    pio_wr = 0; tb_oe = 0; pio_rd = 1;
  endtask

  task automatic run_xfer(input logic [15:0] a, input logic [15:0] n, input bit m2d, input bit inject);
    pio_write(a);
    step(0);
    check(pio_data[1] == 1'b0, "R10 done cleared by address write", pio_data[1], 0);
    pio_write(n);
    exp_addr = a; remaining = n; mem_cycles = 0; dir_m2d = m2d; exp_q.delete();
    pio_write({15'h0, m2d});
    for (int i = 0; i < 3000 && remaining > 0; i++) begin
      if (inject && i == 3) pio_write(16'h0055);
      else step(1);
    end
    step(1);
    check(pio_data[1] == 1'b1, "R7 done flag", pio_data[1], 1);
    check(mem_cycles == n, "R7 memory cycle count", mem_cycles, n);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h1000 + 16'(i * 7);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    pio_rd = 1;
    step(0);
    check(pio_data == 16'h0, "R1 reset status", pio_data, 0);
    check(!mem_req && !dev_out_valid && !dev_in_ready, "R1 reset outputs",
          {mem_req, dev_out_valid, dev_in_ready}, 0);

    // R4 R3 memory to device, continuous grant
    gnt_div = 1; rdy_div = 1;
    run_xfer(16'h0010, 16'd5, 1, 0);

    // R5 device to memory, grant every other cycle
    for (int i = 0; i < 4; i++) src_q.push_back(16'hA000 + 16'(i));
    gnt_div = 2; rdy_div = 3;
    run_xfer(16'h0020, 16'd4, 0, 0);
    check(mem[6'h23] == 16'hA003, "R5 memory content", mem[6'h23], 16'hA003);

    // R6 R9 sparse grant, write injected while busy
    gnt_div = 4; rdy_div = 2;
    run_xfer(16'h0030, 16'd3, 1, 1);

    // R8 zero count
    gnt_div = 1; rdy_div = 1;
    run_xfer(16'h0005, 16'd0, 1, 0);
    check(pio_data[0] == 1'b0, "R8 never busy", pio_data[0], 0);

    // R3 address wrap, device to memory
    for (int i = 0; i < 3; i++) src_q.push_back(16'h5A00 + 16'(i));
    gnt_div = 3; rdy_div = 1;
    run_xfer(16'hFFFE, 16'd3, 0, 0);
    check(mem[0] == 16'h5A02, "R3 wrapped address write", mem[0], 16'h5A02);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule